// File: doc/BRIEF.md
# Five-Operand Column-Counter Adder

This block adds five unsigned operands of equal width `W` in one combinational pass and returns the sum modulo 2^W. Instead of starting with a tree of 3:2 carry-save cells, every bit column first goes through a counter that reports how many of its five bits are set. The per-column counts are then folded into a final carry-propagate addition, and every bit above position W-1 is thrown away.

The `PAIRED` parameter selects the counter shape. With `PAIRED = 0`, each column has its own five-input counter. Its 3-bit count feeds three vectors of weight 1, 2 and 4. A single carry-save row takes these three vectors down to two, and a carry-propagate adder finishes the sum. With `PAIRED = 1`, two neighbouring columns share one counter that returns a 4-bit weighted count of their ten bits. Because adjacent pair outputs do not overlap in alternate positions, they already form two vectors, and only the carry-propagate adder remains. When `W` is odd, the top column gets a pair whose upper half is tied to zero. Both settings give the same result for every input.

Top module: `five_operand_adder`

## Requirements
- R1: For every input combination, `y` equals (a+b+c+d+e) mod 2^W, with the operands taken as unsigned integers.
- R2: Carries out of bit W-1 are discarded. With all five operands at all-ones, `y` is (5·(2^W−1)) mod 2^W.
- R3: `PAIRED = 1` gives exactly the same `y` as `PAIRED = 0` for every input.
- R4: With odd `W` in paired mode, the top column is counted by a pair whose upper column is zero, and the result still meets R1.
- R5: A single column's count never exceeds five. With all five operands equal to 2^i, `y` is (5·2^i) mod 2^W.
- R6: The block has no clock and no state. `y` settles to the new sum within the same time step as an input change.
- R7: In single-column mode, the carry-save row keeps the modular sum of its three input vectors, including patterns where every column produces carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| c | input | W | Third operand |
| d | input | W | Fourth operand |
| e | input | W | Fifth operand |
| y | output | W | Sum of the five operands modulo 2^W |

## Verification
The hardest case to reach is the lone top pair in paired mode with odd width. Its counter must see a zero upper column, and its weight-4 and weight-8 outputs fall entirely beyond the kept width. An exhaustive sweep of all 2^15 input combinations at W=3 reaches every count in that top column and compares the paired and single-column builds against the reference sum. A random run at W=7 covers the same corner at a larger size. Directed all-ones and one-hot-column patterns force the widest counts and the longest carry chains.

// File: rtl/five_operand_adder.sv
module five_operand_adder #(
  parameter int W      = 8,
  parameter bit PAIRED = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  input  logic [W-1:0] e,
  output logic [W-1:0] y
);
  localparam int NP = (W + 1) / 2;
  localparam int PW = 2 * NP;

  logic [W-1:0] ref_sum;
  assign ref_sum = a + b + c + d + e;

  generate
    if (!PAIRED) begin : g_col
      logic [W-1:0] t0, t1, t2, ps, pc;
      assign t1[0]   = 1'b0;
      assign t2[1:0] = 2'b00;
      for (genvar i = 0; i < W; i++) begin : g_cnt
        logic [2:0] n;
        assign n = 3'(a[i]) + 3'(b[i]) + 3'(c[i]) + 3'(d[i]) + 3'(e[i]);
        assign t0[i] = n[0];
        if (i + 1 < W) begin : g_w2
          assign t1[i+1] = n[1];
        end
        if (i + 2 < W) begin : g_w4
          assign t2[i+2] = n[2];
        end
        always_comb begin
          // R5
          cnt_range_chk: assert (!(n[2] && n[1]));
        end
      end
      assign ps = t0 ^ t1 ^ t2;
      assign pc = ((t0 & t1) | (t0 & t2) | (t1 & t2)) << 1;
      assign y  = ps + pc;
      always_comb begin
        // R1
        counter_sum_chk: assert ((t0 + t1 + t2) == ref_sum);
        // R7
        csa_keep_chk: assert ((ps + pc) == (t0 + t1 + t2));
      end
    end else begin : g_pair
      logic [PW-1:0]   ae, be, ce, de, ee;
      logic [PW-1:0]   v0;
      logic [PW+1:0]   v1;
      assign ae = PW'(a);
      assign be = PW'(b);
      assign ce = PW'(c);
      assign de = PW'(d);
      assign ee = PW'(e);
      assign v1[1:0] = 2'b00;
      for (genvar k = 0; k < NP; k++) begin : g_cnt
        logic [2:0] lo, hi;
        logic [3:0] q;
        assign lo = 3'(ae[2*k]) + 3'(be[2*k]) + 3'(ce[2*k]) + 3'(de[2*k]) + 3'(ee[2*k]);
        assign hi = 3'(ae[2*k+1]) + 3'(be[2*k+1]) + 3'(ce[2*k+1])
                  + 3'(de[2*k+1]) + 3'(ee[2*k+1]);
        assign q  = 4'(lo) + {hi, 1'b0};
        assign v0[2*k+1:2*k]   = q[1:0];
        assign v1[2*k+3:2*k+2] = q[3:2];
        always_comb begin
          // R5
          pair_range_chk: assert (!(lo[2] && lo[1]) && !(hi[2] && hi[1]));
        end
      end
      assign y = v0[W-1:0] + v1[W-1:0];
      always_comb begin
        // R3
        pair_vec_chk: assert (W'(v0 + v1) == ref_sum);
      end
    end
  endgenerate

  always_comb begin
    // R1
    sum_mod_chk: assert (y == ref_sum);
  end
endmodule

// File: tb/tb_five_operand_adder.sv
module tb_five_operand_adder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0] a3, b3, c3, d3, e3;
  logic [7:0] a8, b8, c8, d8, e8;
  logic [6:0] a7, b7, c7, d7, e7;
  logic [2:0] y3s, y3p;
  logic [7:0] y8s, y8p;
  logic [6:0] y7s, y7p;

  five_operand_adder #(.W(3), .PAIRED(1'b0)) dut    (.a(a3), .b(b3), .c(c3), .d(d3), .e(e3), .y(y3s));
  five_operand_adder #(.W(3), .PAIRED(1'b1)) dut_3p (.a(a3), .b(b3), .c(c3), .d(d3), .e(e3), .y(y3p));
  five_operand_adder #(.W(8), .PAIRED(1'b0)) dut_8s (.a(a8), .b(b8), .c(c8), .d(d8), .e(e8), .y(y8s));
  five_operand_adder #(.W(8), .PAIRED(1'b1)) dut_8p (.a(a8), .b(b8), .c(c8), .d(d8), .e(e8), .y(y8p));
  five_operand_adder #(.W(7), .PAIRED(1'b0)) dut_7s (.a(a7), .b(b7), .c(c7), .d(d7), .e(e7), .y(y7s));
  five_operand_adder #(.W(7), .PAIRED(1'b1)) dut_7p (.a(a7), .b(b7), .c(c7), .d(d7), .e(e7), .y(y7p));

  function automatic int unsigned sum5(int unsigned p, int unsigned q, int unsigned r,
                                       int unsigned s, int unsigned t, int w);
    int unsigned tot = p + q + r + s + t;
    return tot & ((32'd1 << w) - 1);
  endfunction

  task automatic chk(string req, int unsigned got, int unsigned exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic drive8(logic [7:0] p, logic [7:0] q, logic [7:0] r, logic [7:0] s, logic [7:0] t);
    a8 = p; b8 = q; c8 = r; d8 = s; e8 = t;
  endtask

  task automatic drive7(logic [6:0] p, logic [6:0] q, logic [6:0] r, logic [6:0] s, logic [6:0] t);
    a7 = p; b7 = q; c7 = r; d7 = s; e7 = t;
  endtask

  task automatic check8(string req);
    int unsigned x = sum5(a8, b8, c8, d8, e8, 8);
    chk(req, y8s, x);
    chk(req, y8p, x);
  endtask

  task automatic check7(string req);
    int unsigned x = sum5(a7, b7, c7, d7, e7, 7);
    chk(req, y7s, x);
    chk(req, y7p, x);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240607);
    {a3, b3, c3, d3, e3} = '0;
    drive8(0, 0, 0, 0, 0);
    drive7(0, 0, 0, 0, 0);
    @(negedge clk);
    // R1 idle state: zero operands give zero
    chk("R1", y3s, 0);
    chk("R1", y8s, 0);
    chk("R3", y8p, 0);

    // R1 R3 R4 exhaustive sweep at W=3 (odd width, lone top pair)
    for (int v = 0; v < 32768; v++) begin
      @(posedge clk);
      {a3, b3, c3, d3, e3} = 15'(v);
      @(negedge clk);
      chk("R1", y3s, sum5(a3, b3, c3, d3, e3, 3));
      chk("R4", y3p, sum5(a3, b3, c3, d3, e3, 3));
      chk("R3", y3p, y3s);
    end

    // R2 all-ones operands
    @(posedge clk);
    drive8(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    drive7(7'h7F, 7'h7F, 7'h7F, 7'h7F, 7'h7F);
    @(negedge clk);
    chk("R2", y8s, (5 * 255) & 255);
    chk("R2", y8p, (5 * 255) & 255);
    chk("R2", y7s, (5 * 127) & 127);
    chk("R2", y7p, (5 * 127) & 127);

    // R5 one full column at a time
    for (int i = 0; i < 8; i++) begin
      @(posedge clk);
      drive8(8'(1 << i), 8'(1 << i), 8'(1 << i), 8'(1 << i), 8'(1 << i));
      @(negedge clk);
      chk("R5", y8s, (5 << i) & 255);
      chk("R5", y8p, (5 << i) & 255);
    end

    // R7 carry-heavy patterns
    @(posedge clk);
    drive8(8'h33, 8'h33, 8'h33, 8'h33, 8'h33);
    @(negedge clk);
    check8("R7");
    @(posedge clk);
    drive8(8'hAA, 8'h55, 8'hFF, 8'h01, 8'h7F);
    @(negedge clk);
    check8("R7");

    // R6 combinational response without a clock edge
    @(negedge clk);
    drive8(8'h12, 8'h34, 8'h56, 8'h78, 8'h9A);
    #1;
    chk("R6", y8s, sum5(8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8));
    drive8(8'h01, 8'h02, 8'h03, 8'h04, 8'h05);
    #1;
    chk("R6", y8p, 15);

    // R1 R3 R4 random vectors at W=8 and W=7
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk);
      drive8(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      drive7(7'($urandom), 7'($urandom), 7'($urandom), 7'($urandom), 7'($urandom));
      @(negedge clk);
      check8("R1");
      check7("R4");
      chk("R3", y8p, y8s);
      chk("R3", y7p, y7s);
    end
    finish_run();
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog got=%0d expected=%0d", 150000, 0);
      finish_run();
    end
  end
endmodule